// File: doc/BRIEF.md
# Context-Driven Result Write-Back Unit

This unit moves 128-bit results out of a bank of inter-unit result buffers and into an I/O buffer memory. A static schedule presents one context number per cycle. The unit looks that number up in a context table. The table entry names the source buffer, the 128-bit word address in the I/O buffer, a 16-bit byte mask, and a lane shuffle over the eight 16-bit lanes of the word. No command words travel with the data: every choice about where the data goes and how it is arranged comes from the context number alone.

A context is taken only while its source buffer holds valid data. Taking it frees that buffer in the same cycle. The selected word passes through a full 8x8 crossbar of 16-bit lanes, and one clock later it is presented to the I/O buffer together with its address and byte mask. The unit can take a new context every cycle, so a schedule can store a word on each clock while the sources keep up. The context table and the buffer contents arrive as flat input vectors. The storage behind them, and the way they are filled, lie outside this unit.

Top module: `wbu_top`

## Requirements
- R1: While reset is held and afterwards until the first accepted context, `memWe` is 0 and `memBe` is 0.
- R2: A presented context (`issueValid`=1) is accepted (`issueAccept`=1) in a cycle if and only if the buffer named by its source index has `bufValid` set. Otherwise it is held off and causes no write.
- R3: In a cycle where a context is accepted, `bufConsume` has exactly one bit set: the bit of that context's source buffer. In every other cycle, `bufConsume` is zero.
- R4: A context accepted in cycle k produces `memWe`=1 in cycle k+1 only, with `memAddr` equal to the address field of its table entry. Without an acceptance in cycle k, `memWe` is 0 in cycle k+1.
- R5: The written word is taken from the buffer named by the source index, as it was in the cycle of acceptance. Buffer b occupies bits 128*b+127 to 128*b of `bufData`.
- R6: Output lane i of `memData` (bits 16*i+15 to 16*i) equals input lane s, where s is the 3-bit select at bits 3*i+2 to 3*i of the entry's lane-select field. Selects may repeat, so a lane may be duplicated.
- R7: `memBe` during a write equals the entry's byte-mask field, with bit j covering `memData` bits 8*j+7 to 8*j. `memBe` is zero whenever `memWe` is 0.
- R8: Contexts presented in consecutive cycles, each with a valid source, are all accepted and produce writes in consecutive cycles, in order.
- R9: Table entry c occupies bits ENT_W*c+ENT_W-1 to ENT_W*c of `cfgTable`. Its fields, from the least significant bit up, are: source index (SRC_W bits), word address (ADDR_W bits), byte mask (16 bits), lane selects (24 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A context is presented this cycle |
| issueCtx | input | CTX_W | Presented context number |
| issueAccept | output | 1 | Presented context is taken this cycle |
| cfgTable | input | NUM_CTX*ENT_W | Flat context table |
| bufValid | input | NUM_BUF | Valid flag of each result buffer |
| bufData | input | NUM_BUF*128 | Contents of each result buffer |
| bufConsume | output | NUM_BUF | One-hot release of the buffer just read |
| memWe | output | 1 | I/O buffer write strobe |
| memAddr | output | ADDR_W | 128-bit word address |
| memBe | output | 16 | Byte enables of the write |
| memData | output | 128 | Shuffled write data |

## Verification
The hardest case to reach from the ports is a context that is held off because its source is empty and is then accepted once, at a later edge, while the schedule keeps presenting it. The stimulus holds one context for several cycles with its source flag low and other sources valid, then raises the flag. The scoreboard expects exactly one consume pulse and exactly one write, one cycle after the flag rises. A run of all eight contexts on consecutive cycles, with tables that duplicate, reverse and rotate lanes, exercises the crossbar and back-to-back writes.

// File: rtl/wbu_pkg.sv
package wbu_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 16;
  localparam int WORD_W = LANES * LANE_W;
  localparam int SEL_W  = $clog2(LANES);
  localparam int XBAR_W = LANES * SEL_W;
  localparam int BE_W   = WORD_W / 8;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic              load;
    logic [XBAR_W-1:0] xbar;
    logic [BE_W-1:0]   be;
  } wbu_strobe_t;
endpackage

// File: rtl/wbu_ctl.sv
module wbu_ctl
  import wbu_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int NUM_BUF = 4,
  parameter int ADDR_W  = 10,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int SRC_W  = $clog2(NUM_BUF),
  localparam int ENT_W  = SRC_W + ADDR_W + BE_W + XBAR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     issueValid,
  input  logic [CTX_W-1:0]         issueCtx,
  input  logic [NUM_CTX*ENT_W-1:0] cfgTable,
  input  logic [NUM_BUF-1:0]       bufValid,
  output logic                     issueAccept,
  output logic [NUM_BUF-1:0]       bufConsume,
  output logic [SRC_W-1:0]         srcIdx,
  output logic [ADDR_W-1:0]        wrAddr,
  output wbu_strobe_t              strobe
);
  logic [ENT_W-1:0] entry;

  assign entry  = cfgTable[ENT_W*int'(issueCtx) +: ENT_W];
  assign srcIdx = entry[SRC_W-1:0];
  assign wrAddr = entry[SRC_W +: ADDR_W];

  assign issueAccept = issueValid && bufValid[srcIdx];

  always_comb begin
    strobe.load = issueAccept;
    strobe.be   = entry[SRC_W+ADDR_W +: BE_W];
    strobe.xbar = entry[SRC_W+ADDR_W+BE_W +: XBAR_W];
  end

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_consume
    assign bufConsume[b] = issueAccept && (srcIdx == SRC_W'(b));
  end

  p_consume_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bufConsume));
  p_consume_on_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    issueAccept |-> $countones(bufConsume) == 1);
  p_consume_valid_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bufConsume & ~bufValid) == '0);
  p_no_consume_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !issueAccept |-> bufConsume == '0);
endmodule

// File: rtl/wbu_dp.sv
module wbu_dp
  import wbu_pkg::*;
#(
  parameter int NUM_BUF = 4,
  parameter int ADDR_W  = 10,
  localparam int SRC_W  = $clog2(NUM_BUF)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wbu_strobe_t               strobe,
  input  logic [SRC_W-1:0]          srcIdx,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [NUM_BUF*WORD_W-1:0] bufData,
  output logic                      memWe,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [BE_W-1:0]           memBe,
  output logic [WORD_W-1:0]         memData
);
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] shuffled;

  assign srcWord = bufData[WORD_W*int'(srcIdx) +: WORD_W];

  // Full crossbar: each output lane picks any input lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0] laneSel;
    assign laneSel = strobe.xbar[SEL_W*g +: SEL_W];
    assign shuffled[LANE_W*g +: LANE_W] = srcWord[LANE_W*int'(laneSel) +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memBe   <= '0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= strobe.load;
      memBe <= strobe.load ? strobe.be : '0;
      if (strobe.load) begin
        memAddr <= wrAddr;
        memData <= shuffled;
      end
    end
  end

  p_write_follows_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> memWe);
  p_no_spurious_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !memWe);
  p_idle_mask_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memWe |-> memBe == '0);
  p_addr_held_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(memAddr));
endmodule

// File: rtl/wbu_top.sv
module wbu_top
  import wbu_pkg::*;
#(
  parameter int NUM_CTX = 8,
  parameter int NUM_BUF = 4,
  parameter int ADDR_W  = 10,
  localparam int CTX_W  = $clog2(NUM_CTX),
  localparam int SRC_W  = $clog2(NUM_BUF),
  localparam int ENT_W  = SRC_W + ADDR_W + BE_W + XBAR_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      issueValid,
  input  logic [CTX_W-1:0]          issueCtx,
  output logic                      issueAccept,
  input  logic [NUM_CTX*ENT_W-1:0]  cfgTable,
  input  logic [NUM_BUF-1:0]        bufValid,
  input  logic [NUM_BUF*WORD_W-1:0] bufData,
  output logic [NUM_BUF-1:0]        bufConsume,
  output logic                      memWe,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [BE_W-1:0]           memBe,
  output logic [WORD_W-1:0]         memData
);
  wbu_strobe_t       strobe;
  logic [SRC_W-1:0]  srcIdx;
  logic [ADDR_W-1:0] wrAddr;

  wbu_ctl #(.NUM_CTX(NUM_CTX), .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueCtx(issueCtx),
    .cfgTable(cfgTable), .bufValid(bufValid), .issueAccept(issueAccept),
    .bufConsume(bufConsume), .srcIdx(srcIdx), .wrAddr(wrAddr), .strobe(strobe)
  );

  wbu_dp #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcIdx(srcIdx), .wrAddr(wrAddr),
    .bufData(bufData), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memData(memData)
  );
endmodule

// File: tb/tb_wbu_top.sv
module tb_wbu_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTX = 8;
  localparam int NUM_BUF = 4;
  localparam int ADDR_W  = 10;
  localparam int CTX_W   = 3;
  localparam int SRC_W   = 2;
  localparam int ENT_W   = SRC_W + ADDR_W + 16 + 24;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     issueValid = 1'b0;
  logic [CTX_W-1:0]         issueCtx = '0;
  logic                     issueAccept;
  logic [NUM_CTX*ENT_W-1:0] cfgTable = '0;
  logic [NUM_BUF-1:0]       bufValid = '0;
  logic [NUM_BUF*128-1:0]   bufData = '0;
  logic [NUM_BUF-1:0]       bufConsume;
  logic                     memWe;
  logic [ADDR_W-1:0]        memAddr;
  logic [15:0]              memBe;
  logic [127:0]             memData;

  wbu_top #(.NUM_CTX(NUM_CTX), .NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueCtx(issueCtx),
    .issueAccept(issueAccept), .cfgTable(cfgTable), .bufValid(bufValid),
    .bufData(bufData), .bufConsume(bufConsume), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memData(memData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int           cyc;
    logic [9:0]   addr;
    logic [15:0]  be;
    logic [127:0] data;
  } exp_t;

  exp_t expQ[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int srcOf [NUM_CTX] = '{0, 1, 2, 3, 0, 1, 2, 3};
  int addrOf[NUM_CTX] = '{'h010, 'h3FF, 'h000, 'h155, 'h2A0, 'h001, 'h100, 'h0F0};
  int beOf  [NUM_CTX] = '{'hFFFF, 'h00FF, 'hF00F, 'h0001, 'hAAAA, 'h0000, 'hFFFF, 'h5555};

  function automatic int laneSel(int c, int i);
    case (c)
      0: return i;
      1: return 7 - i;
      2: return 5;
      3: return (i + 1) % 8;
      4: return i ^ 1;
      5: return i;
      6: return (i * 3) % 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [127:0] shuffle(logic [127:0] w, int c);
    logic [127:0] r;
    for (int i = 0; i < 8; i++) r[16*i +: 16] = w[16*laneSel(c, i) +: 16];
    return r;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: presents one context for one cycle, checks handshake, pushes expectation
  task automatic drive(bit v, int c, logic [3:0] bv);
    bit expAcc;
    @(posedge clk); #1;
    issueValid = v;
    issueCtx   = CTX_W'(c);
    bufValid   = bv;
    @(negedge clk);
    expAcc = v && bv[srcOf[c]];
    check(issueAccept == expAcc, "R2", "accept", 128'(issueAccept), 128'(expAcc));
    check(bufConsume == (expAcc ? 4'(1 << srcOf[c]) : 4'b0), "R3", "consume",
          128'(bufConsume), expAcc ? 128'(1 << srcOf[c]) : 128'(0));
    if (expAcc) begin
      exp_t e;
      e.cyc  = cyc;
      e.addr = 10'(addrOf[c]);
      e.be   = 16'(beOf[c]);
      e.data = shuffle(bufData[128*srcOf[c] +: 128], c);
      expQ.push_back(e);
    end
  endtask

  // Monitor: each cycle a write is expected iff an acceptance happened one cycle earlier
  always @(negedge clk) begin
    if (rstN && !finished) begin
      bit want;
      want = (expQ.size() > 0) && (expQ[0].cyc == cyc - 1);
      check(memWe == want, "R4", "write strobe timing", 128'(memWe), 128'(want));
      if (!memWe) check(memBe == 16'h0, "R7", "idle mask", 128'(memBe), 128'h0);
      if (want) begin
        exp_t e;
        e = expQ.pop_front();
        check(memAddr == e.addr, "R4", "address", 128'(memAddr), 128'(e.addr));
        check(memBe == e.be, "R7", "byte mask", 128'(memBe), 128'(e.be));
        check(memData == e.data, "R6", "R5 source and lane shuffle", memData, e.data);
      end
    end
  end

  initial begin
    // R9 table layout
    for (int c = 0; c < NUM_CTX; c++) begin
      logic [23:0] xb;
      for (int i = 0; i < 8; i++) xb[3*i +: 3] = 3'(laneSel(c, i));
      cfgTable[ENT_W*c +: ENT_W] = {xb, 16'(beOf[c]), 10'(addrOf[c]), 2'(srcOf[c])};
    end
    for (int b = 0; b < NUM_BUF; b++)
      for (int l = 0; l < 8; l++)
        bufData[128*b + 16*l +: 16] = {4'(b + 1), 4'(l), 8'(b * 8 + l + 8'h30)};

    repeat (3) @(negedge clk);
    check(memWe == 1'b0, "R1", "write strobe in reset", 128'(memWe), 128'h0);
    check(memBe == 16'h0, "R1", "mask in reset", 128'(memBe), 128'h0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(memWe == 1'b0, "R1", "write strobe after reset", 128'(memWe), 128'h0);

    drive(1, 0, 4'hF);                 // single identity write
    drive(0, 0, 4'h0);
    drive(1, 1, 4'b1101);              // R2: source 1 empty, held off
    drive(0, 0, 4'hF);
    drive(0, 2, 4'hF);                 // not presented, valid sources: no accept
    for (int c = 0; c < NUM_CTX; c++)  // R8: back-to-back, all contexts
      drive(1, c, 4'hF);
    drive(0, 0, 4'h0);
    for (int k = 0; k < 3; k++)        // R2: context 3 stalls on empty source 3
      drive(1, 3, 4'b0111);
    drive(1, 3, 4'b1111);              // accepted once
    drive(1, 6, 4'b1011);              // source 2 empty: held
    bufData[128*2 +: 128] = {8{16'hC3A5}} ^ bufData[128*2 +: 128];
    drive(1, 6, 4'b0100);              // R5: updated contents of buffer 2
    drive(1, 2, 4'b0100);              // R6: broadcast lane
    drive(0, 0, 4'h0);
    repeat (3) drive(0, 0, 4'h0);
    check(expQ.size() == 0, "R4", "pending writes at end", 128'(expQ.size()), 128'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule